// File: doc/BRIEF.md
# Serial Receive FIFO with Sticky Overrun Flag

This block is the receive side of a serial port. Characters completed by a deserializer arrive as a one-cycle strobe with a data byte. They are queued in a first-in first-out buffer of 16 bytes. The CPU drains the buffer through a data register. Each read of that register returns the oldest byte and removes it.

A 16-bit line status register carries a single live bit, the overrun error flag, in bit 0. The flag goes high when a character completes while the buffer is already full. That character is lost and the buffered bytes are kept. While the flag is high, reception stays stopped. The flag is protected against accidental clearing: software must first read it as 1 and only then write 0. A further overrun after that read cancels the read, so software must read the flag again.

The register bus selects one of two registers with `reg_sel`: 0 is the data register and 1 is the line status register.

Top module: `rx_fifo_ovr`

## Requirements
- R1: After power-on reset, the status register reads 0x0000, the level is 0, empty is 1, full is 0 and rx_halt is 0.
- R2: A strobe with rx_enable high, the buffer not full and the flag at 0 stores the byte. A data-register read (reg_sel=0) returns the oldest byte in bits 7:0, with bits 15:8 at 0, and removes it. A data-register read of an empty buffer returns 0x0000 and changes nothing.
- R3: The level, empty and full outputs take their new values in the cycle after each store or removal. Full means 16 bytes are held.
- R4: A strobe with rx_enable high while the buffer is full sets status bit 0 in the next cycle. The incoming byte is dropped, and the 16 held bytes are kept in their order.
- R5: While status bit 0 is 1, rx_halt is 1 and strobes store nothing.
- R6: Status bits 15:1 always read 0 and ignore writes. Writing 1 to bit 0 never sets the flag.
- R7: Writing 0 to status bit 0 without a prior read of it as 1 leaves the flag at 1.
- R8: A status read that returns bit 0 as 1, followed by a write with bit 0 equal to 0, clears the flag in the next cycle.
- R9: An overrun that occurs after that read cancels it, so a later write of 0 leaves the flag at 1.
- R10: When an overrun and a valid clearing write fall in the same cycle, the flag stays 1.
- R11: While rx_enable is 0, strobes are ignored. Neither the buffer nor the flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| rx_strobe | input | 1 | Character completed by the deserializer |
| rx_byte | input | 8 | Received character |
| rx_enable | input | 1 | Receive enable |
| reg_sel | input | 1 | Register select: 0 data, 1 line status |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid in the read cycle |
| fifo_level | output | 5 | Number of bytes held |
| fifo_empty | output | 1 | Buffer holds no byte |
| fifo_full | output | 1 | Buffer holds 16 bytes |
| lsr_value | output | 16 | Line status register value |
| rx_halt | output | 1 | Reception stopped by an overrun |

## Verification
The embedded assertions check several rules on every clock:
- the level never exceeds the depth;
- a full strobe raises the flag;
- the level is frozen on a dropped byte;
- the flag survives writes that do not qualify as clearing and a low receive enable;
- a clear happens only after an armed read.

Some properties only the bench scenarios can show. These are the byte order through every fill level from 0 to 16, the preservation of the held bytes across an overrun, cancelling the armed read by a later overrun, and the exact cycle at which the flag falls.

// File: rtl/rx_fifo_ovr.sv
module rx_fifo_ovr #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_strobe,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_enable,
  input  logic              reg_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [LW-1:0]     fifo_level,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [15:0]       lsr_value,
  output logic              rx_halt
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic [LW-1:0]     cnt;
  logic              ovr, armed;

  wire full    = (cnt == LW'(DEPTH));
  wire empty   = (cnt == '0);
  wire rx_take = rx_strobe & rx_enable;
  wire push    = rx_take & ~full & ~ovr;
  wire set_ovr = rx_take & full;
  wire pop     = reg_rd & ~reg_sel & ~empty;
  wire stat_rd = reg_rd & reg_sel;
  wire stat_wr = reg_wr & reg_sel;
  wire clr     = stat_wr & ~reg_wdata[0] & armed;

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[15:1];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovr   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_ovr)  ovr <= 1'b1;
      else if (clr) ovr <= 1'b0;
      if (set_ovr || clr)   armed <= 1'b0;
      else if (stat_rd && ovr) armed <= 1'b1;
    end

  assign lsr_value  = {15'b0, ovr};
  assign reg_rdata  = reg_sel ? lsr_value : (empty ? 16'h0000 : 16'(mem[rp]));
  assign fifo_level = cnt;
  assign fifo_empty = empty;
  assign fifo_full  = full;
  assign rx_halt    = ovr;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LW'(DEPTH)); // R3
  AST_SET_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_enable && fifo_full) |=> lsr_value[0]); // R4
  AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && rx_enable && fifo_full && !(reg_rd && !reg_sel)) |=> $stable(fifo_level)); // R4
  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_halt && !(reg_rd && !reg_sel)) |=> $stable(fifo_level)); // R5
  AST_WR1_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsr_value[0] && !(rx_strobe && rx_enable && fifo_full)) |=> !lsr_value[0]); // R6
  AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_value[0] && !armed) |=> lsr_value[0]); // R7
  AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !(reg_rd && !reg_sel)) |=> $stable(fifo_level)); // R11

endmodule

// File: tb/test_rx_fifo_ovr.sv
module test_rx_fifo_ovr;
  logic clk = 0, rst_n = 0;
  logic rx_strobe = 0, rx_enable = 1, reg_sel = 0, reg_rd = 0, reg_wr = 0;
  logic [7:0] rx_byte = 0;
  logic [15:0] reg_wdata = 0, reg_rdata, lsr_value;
  logic [4:0] fifo_level;
  logic fifo_empty, fifo_full, rx_halt;
  int errors = 0, checks = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  rx_fifo_ovr i_rx_fifo_ovr (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int i);
    return 8'((k * 29 + i * 53 + 7) & 255);
  endfunction

  task automatic push(input logic [7:0] b);
    @(negedge clk); rx_strobe = 1; rx_byte = b;
    @(negedge clk); rx_strobe = 0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < 16; i++) push(pat(k, i));
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 status", lsr_value, 0);
    check("R1 level", fifo_level, 0);
    check("R1 empty", fifo_empty, 1);
    check("R1 full", fifo_full, 0);
    check("R1 halt", rx_halt, 0);

    for (int k = 0; k <= 16; k++) begin
      for (int i = 0; i < k; i++) push(pat(k, i));
      check("R3 level", fifo_level, k);
      check("R3 empty", fifo_empty, k == 0);
      check("R3 full", fifo_full, k == 16);
      for (int i = 0; i < k; i++) begin
        rd(0, v);
        check("R2 order", v, pat(k, i));
      end
      rd(0, v);
      check("R2 empty read", v, 0);
      check("R2 empty level", fifo_level, 0);
    end

    fill(99);
    push(8'hA5);
    check("R4 flag set", lsr_value, 1);
    check("R4 level kept", fifo_level, 16);
    check("R5 halt", rx_halt, 1);
    wr(16'h0000);
    check("R7 write0 unread", lsr_value, 1);
    wr(16'hFFFF);
    check("R6 write1", lsr_value, 1);
    rd(1, v);
    check("R6 reserved read", v, 1);
    push(8'h5A);
    check("R5 halted no store", fifo_level, 16);
    wr(16'h0000);
    check("R9 disarmed by new overrun", lsr_value, 1);
    rd(1, v);
    wr(16'hFFFE);
    check("R8 cleared", lsr_value, 0);
    check("R8 halt released", rx_halt, 0);
    for (int i = 0; i < 16; i++) begin
      rd(0, v);
      check("R4 contents kept", v, pat(99, i));
    end
    wr(16'hFFFF);
    check("R6 write1 no set", lsr_value, 0);

    fill(7);
    push(8'h11);
    rd(1, v);
    @(negedge clk);
    rx_strobe = 1; reg_sel = 1; reg_wr = 1; reg_wdata = 0;
    @(negedge clk);
    rx_strobe = 0; reg_wr = 0;
    check("R10 set wins", lsr_value, 1);
    wr(16'h0000);
    check("R10 read needed again", lsr_value, 1);

    rx_enable = 0;
    rd(1, v);
    wr(16'h0000);
    check("R11 flag cleared while disabled", lsr_value, 0);
    push(8'h22);
    check("R11 full strobe ignored", lsr_value, 0);
    for (int i = 0; i < 16; i++) rd(0, v);
    push(8'h33);
    check("R11 no store", fifo_level, 0);
    rx_enable = 1;
    fill(3);
    push(8'h44);
    rx_enable = 0;
    repeat (3) @(negedge clk);
    check("R11 flag kept", lsr_value, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule